// File: doc/BRIEF.md
# Serial Command Frame Receiver

This block sits behind a UART or SPI byte receiver and turns the incoming byte stream into command frames. It waits for a start-of-frame byte (0xFE). It then reads a two-byte length, a combined type/subsystem byte and an opcode byte. Next it passes the payload bytes through one at a time, and finally compares a trailing check byte against the running XOR of the frame.

Header fields are presented with a one-cycle header strobe and held until the next frame replaces them. Payload bytes leave as a valid/last stream. Each completed frame produces a done pulse carrying a checksum-good or checksum-error verdict. A frame whose declared payload exceeds the configured limit is dropped at the length stage with an overflow pulse. A byte counter for the current frame is exposed so that a handshake controller can tell when the exchange has finished.

Type codes seen on `msg_type` are 1 for a synchronous request, 2 for an asynchronous request or indication, and 3 for a synchronous response. The block reports the code and does not act on it.

Top module: `cmd_frame_rx`

## Requirements
- R1: While hunting, every accepted byte other than 0xFE is discarded: it produces no strobe and leaves `byte_cnt` unchanged. 0xFE starts a frame and sets `byte_cnt` to 1.
- R2: The two bytes after the start byte form the length, low byte first. Bits 13:0 of that value are the payload byte count and appear on `pay_len`.
- R3: Length bits 15:14 (bits 7:6 of the second length byte) are reserved. If either is set, `rsvd_seen` goes high and parsing continues. The flag clears at the next start byte.
- R4: The byte after the length drives `msg_type` from its bits 7:5 and `subsys` from its bits 4:0. The following byte drives `opcode`. `hdr_valid` pulses for one cycle after the opcode byte.
- R5: Exactly `pay_len` payload bytes leave on `pay_data` with `pay_valid`, in arrival order. `pay_last` marks only the final one. A zero length gives no `pay_valid`. A 0xFE inside the payload is ordinary data.
- R6: The byte after the payload is the check byte. `frame_done` pulses once, with `csum_ok` set if the check byte equals the XOR of all bytes from the first length byte through the last payload byte, and with `csum_err` set otherwise. Both verdict outputs are low when `frame_done` is low.
- R7: After the check byte the parser hunts again, so back-to-back frames with no gap are each recovered.
- R8: If the declared payload count exceeds `MAX_PAY` (default 530), `ovf_err` pulses after the second length byte. The frame is abandoned with no header strobe, no payload and no `frame_done`, and the parser hunts again. A count equal to `MAX_PAY` is accepted.
- R9: `byte_cnt` counts the accepted bytes of the current frame, start byte included. It equals payload count plus 6 after a complete frame and holds until the next start byte.
- R10: Cycles with `in_valid` low change no state and produce no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received byte is present this cycle |
| in_byte | input | 8 | Received byte |
| hdr_valid | output | 1 | One-cycle strobe: header fields updated |
| msg_type | output | 3 | Message type code |
| subsys | output | 5 | Subsystem identifier |
| opcode | output | 8 | Command opcode |
| pay_len | output | 14 | Declared payload byte count |
| rsvd_seen | output | 1 | Reserved length bits were nonzero in this frame |
| pay_valid | output | 1 | Payload byte present on pay_data |
| pay_data | output | 8 | Payload byte |
| pay_last | output | 1 | Final payload byte of the frame |
| frame_done | output | 1 | One-cycle strobe: check byte consumed |
| csum_ok | output | 1 | Checksum matched (with frame_done) |
| csum_err | output | 1 | Checksum mismatched (with frame_done) |
| ovf_err | output | 1 | One-cycle strobe: frame dropped, length over limit |
| byte_cnt | output | $clog2(MAX_PAY+7) | Bytes accepted in the current frame |

## Verification
The assertions assume that `in_valid` and `in_byte` are known and settled at each rising edge, and that reset is held for at least one edge before traffic begins. They also assume that `in_valid` is never high during reset in a way that matters, since the hunt state absorbs it. The bench changes inputs only on the falling edge, keeps `in_valid` low through reset, and inserts idle cycles between bytes in some frames, so the claims that idle cycles are quiet and that the count steps once per byte are exercised under both dense and sparse traffic.

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx #(
  parameter int          MAX_PAY = 530,
  parameter logic [7:0]  SOF     = 8'hFE,
  localparam int         LW      = 14,
  localparam int         CW      = $clog2(MAX_PAY + 7)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  output logic          hdr_valid,
  output logic [2:0]    msg_type,
  output logic [4:0]    subsys,
  output logic [7:0]    opcode,
  output logic [LW-1:0] pay_len,
  output logic          rsvd_seen,
  output logic          pay_valid,
  output logic [7:0]    pay_data,
  output logic          pay_last,
  output logic          frame_done,
  output logic          csum_ok,
  output logic          csum_err,
  output logic          ovf_err,
  output logic [CW-1:0] byte_cnt
);

  typedef enum logic [2:0] {S_HUNT, S_LLO, S_LHI, S_CMD0, S_CMD1, S_PAY, S_FCS} st_t;

  st_t          st;
  logic [7:0]   acc;
  logic [7:0]   len_lo;
  logic [LW-1:0] rem;

  wire [LW-1:0] len_new  = {in_byte[5:0], len_lo};
  wire          too_long = int'(len_new) > MAX_PAY;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_HUNT;
      acc        <= '0;
      len_lo     <= '0;
      rem        <= '0;
      hdr_valid  <= 1'b0;
      msg_type   <= '0;
      subsys     <= '0;
      opcode     <= '0;
      pay_len    <= '0;
      rsvd_seen  <= 1'b0;
      pay_valid  <= 1'b0;
      pay_data   <= '0;
      pay_last   <= 1'b0;
      frame_done <= 1'b0;
      csum_ok    <= 1'b0;
      csum_err   <= 1'b0;
      ovf_err    <= 1'b0;
      byte_cnt   <= '0;
    end else begin
      hdr_valid  <= 1'b0;
      pay_valid  <= 1'b0;
      pay_last   <= 1'b0;
      frame_done <= 1'b0;
      csum_ok    <= 1'b0;
      csum_err   <= 1'b0;
      ovf_err    <= 1'b0;
      if (in_valid) begin
        if (st != S_HUNT) byte_cnt <= byte_cnt + 1'b1;
        case (st)
          S_HUNT: if (in_byte == SOF) begin
            st        <= S_LLO;
            byte_cnt  <= CW'(1);
            rsvd_seen <= 1'b0;
          end
          S_LLO: begin
            len_lo <= in_byte;
            acc    <= in_byte;
            st     <= S_LHI;
          end
          S_LHI: begin
            acc       <= acc ^ in_byte;
            pay_len   <= len_new;
            rem       <= len_new;
            rsvd_seen <= |in_byte[7:6];
            if (too_long) begin
              ovf_err <= 1'b1;
              st      <= S_HUNT;
            end else begin
              st <= S_CMD0;
            end
          end
          S_CMD0: begin
            acc      <= acc ^ in_byte;
            msg_type <= in_byte[7:5];
            subsys   <= in_byte[4:0];
            st       <= S_CMD1;
          end
          S_CMD1: begin
            acc       <= acc ^ in_byte;
            opcode    <= in_byte;
            hdr_valid <= 1'b1;
            st        <= (rem == '0) ? S_FCS : S_PAY;
          end
          S_PAY: begin
            acc       <= acc ^ in_byte;
            pay_valid <= 1'b1;
            pay_data  <= in_byte;
            pay_last  <= (rem == LW'(1));
            rem       <= rem - 1'b1;
            if (rem == LW'(1)) st <= S_FCS;
          end
          S_FCS: begin
            frame_done <= 1'b1;
            csum_ok    <= (acc == in_byte);
            csum_err   <= (acc != in_byte);
            st         <= S_HUNT;
          end
          default: st <= S_HUNT;
        endcase
      end
    end
  end

  assert_hunt_discard_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HUNT && in_valid && in_byte != SOF) |=> (st == S_HUNT && $stable(byte_cnt)));

  assert_last_in_stream_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pay_last |-> pay_valid);

  assert_done_verdict_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (csum_ok != csum_err));

  assert_no_stray_verdict_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> (!csum_ok && !csum_err));

  assert_done_then_hunt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> st == S_HUNT);

  assert_ovf_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |-> (st == S_HUNT && int'(pay_len) > MAX_PAY));

  assert_cnt_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && st != S_HUNT) |=> byte_cnt == $past(byte_cnt) + 1'b1);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !(hdr_valid || pay_valid || frame_done || ovf_err));

  assert_strobes_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hdr_valid, pay_valid, frame_done, ovf_err}));

endmodule

// File: tb/cmd_frame_rx_tb.sv
`timescale 1ns/1ps
module cmd_frame_rx_tb;
  localparam int MAXP = 530;
  localparam int CW   = $clog2(MAXP + 7);

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [7:0] in_byte = 0;
  logic hdr_valid, rsvd_seen, pay_valid, pay_last, frame_done, csum_ok, csum_err, ovf_err;
  logic [2:0] msg_type;
  logic [4:0] subsys;
  logic [7:0] opcode, pay_data;
  logic [13:0] pay_len;
  logic [CW-1:0] byte_cnt;

  always #2 clk = ~clk;

  cmd_frame_rx #(.MAX_PAY(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .hdr_valid(hdr_valid), .msg_type(msg_type), .subsys(subsys), .opcode(opcode),
    .pay_len(pay_len), .rsvd_seen(rsvd_seen), .pay_valid(pay_valid), .pay_data(pay_data),
    .pay_last(pay_last), .frame_done(frame_done), .csum_ok(csum_ok), .csum_err(csum_err),
    .ovf_err(ovf_err), .byte_cnt(byte_cnt));

  int tests = 0, fails = 0;
  int hdr_n, pay_n, last_n, last_idx, done_n, ovf_n, idle_bad;
  logic [2:0] h_ty; logic [4:0] h_sb; logic [7:0] h_op;
  logic ok_v, err_v;
  logic [7:0] pay_buf [0:1023];

  task automatic chk(input bit cond, input string req, input longint act, input longint exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_rec();
    hdr_n = 0; pay_n = 0; last_n = 0; last_idx = -1; done_n = 0; ovf_n = 0; idle_bad = 0;
    ok_v = 0; err_v = 0;
  endtask

  task automatic idle();
    @(negedge clk); in_valid = 0;
    @(posedge clk); #1;
    if (hdr_valid || pay_valid || frame_done || ovf_err) idle_bad++;
  endtask

  task automatic send(input logic [7:0] b, input int gap);
    @(negedge clk); in_valid = 1; in_byte = b;
    @(posedge clk); #1;
    if (hdr_valid) begin hdr_n++; h_ty = msg_type; h_sb = subsys; h_op = opcode; end
    if (pay_valid) begin
      if (pay_n < 1024) pay_buf[pay_n] = pay_data;
      if (pay_last) begin last_n++; last_idx = pay_n; end
      pay_n++;
    end
    if (frame_done) begin done_n++; ok_v = csum_ok; err_v = csum_err; end
    if (ovf_err) ovf_n++;
    for (int i = 0; i < gap; i++) idle();
  endtask

  function automatic logic [7:0] pbyte(input logic [7:0] seed, input int i);
    return seed + 8'(i * 7);
  endfunction

  task automatic send_frame(input logic [2:0] ty, input logic [4:0] sb, input logic [7:0] op,
                            input int n, input logic [1:0] rs, input bit bad, input int gap,
                            input logic [7:0] seed, input string tag);
    logic [7:0] x, l0, l1;
    int bad_data;
    clear_rec();
    l0 = n[7:0]; l1 = {rs, n[13:8]};
    x = l0 ^ l1 ^ {ty, sb} ^ op;
    send(8'hFE, gap); send(l0, gap); send(l1, gap); send({ty, sb}, gap); send(op, gap);
    for (int i = 0; i < n; i++) begin x ^= pbyte(seed, i); send(pbyte(seed, i), gap); end
    send(bad ? (x ^ 8'h5A) : x, gap);
    bad_data = 0;
    for (int i = 0; i < n && i < 1024; i++) if (pay_buf[i] !== pbyte(seed, i)) bad_data++;
    chk(hdr_n == 1, {tag, " R4 header strobe count"}, hdr_n, 1);
    chk(h_ty == ty && h_sb == sb, {tag, " R4 type/subsystem"}, {h_ty, h_sb}, {ty, sb});
    chk(h_op == op, {tag, " R4 opcode"}, h_op, op);
    chk(pay_len == 14'(n), {tag, " R2 payload length"}, pay_len, n);
    chk(pay_n == n && bad_data == 0, {tag, " R5 payload bytes"}, pay_n, n);
    chk(last_n == (n > 0 ? 1 : 0) && last_idx == n - 1, {tag, " R5 last marker"}, last_idx, n - 1);
    chk(done_n == 1, {tag, " R6 done count"}, done_n, 1);
    chk(ok_v == !bad && err_v == bad, {tag, " R6 verdict"}, {ok_v, err_v}, {!bad, bad});
    chk(rsvd_seen == (rs != 0), {tag, " R3 reserved flag"}, rsvd_seen, rs != 0);
    chk(byte_cnt == CW'(n + 6), {tag, " R9 byte count"}, byte_cnt, n + 6);
    chk(idle_bad == 0, {tag, " R10 idle cycles quiet"}, idle_bad, 0);
  endtask

  task automatic t_reset();
    chk(!hdr_valid && !pay_valid && !frame_done && !csum_ok && !csum_err && !ovf_err,
        "reset strobes low", {hdr_valid, pay_valid, frame_done, ovf_err}, 0);
    chk(byte_cnt == 0 && !rsvd_seen, "reset count/flag", byte_cnt, 0);
  endtask

  task automatic t_hunt();
    clear_rec();
    send(8'h00, 0); send(8'hFD, 1); send(8'hFF, 0); send(8'h7E, 0);
    chk(hdr_n == 0 && pay_n == 0 && done_n == 0 && ovf_n == 0, "R1 garbage discarded",
        hdr_n + pay_n + done_n + ovf_n, 0);
    chk(byte_cnt == 0, "R1 count unchanged while hunting", byte_cnt, 0);
    send(8'hFE, 0);
    chk(byte_cnt == 1, "R1 start byte sets count", byte_cnt, 1);
    send(8'h00, 0); send(8'h00, 0); send(8'h41, 0); send(8'h09, 0); send(8'h41 ^ 8'h09, 0);
  endtask

  task automatic t_overflow();
    clear_rec();
    send(8'hFE, 0); send(8'h13, 0); send(8'h02, 0);
    chk(ovf_n == 1, "R8 overflow strobe at 531", ovf_n, 1);
    send(8'h21, 0); send(8'h05, 0); send(8'hAA, 0); send(8'h8F, 0);
    chk(hdr_n == 0 && pay_n == 0 && done_n == 0, "R8 aborted frame silent",
        hdr_n + pay_n + done_n, 0);
    chk(byte_cnt == 3, "R8 abort count", byte_cnt, 3);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; t_reset();
    @(negedge clk); rst_n = 1;
    t_hunt();
    send_frame(3'd1, 5'h10, 8'h03, 0, 2'b00, 0, 0, 8'h00, "sreq-empty");
    send_frame(3'd2, 5'h15, 8'h7A, 5, 2'b00, 0, 2, 8'h11, "areq-gaps");
    send_frame(3'd3, 5'h0A, 8'hC4, 3, 2'b00, 1, 0, 8'h20, "sresp-badfcs");
    send_frame(3'd2, 5'h1F, 8'hFE, 2, 2'b11, 0, 0, 8'h33, "rsvd");
    send_frame(3'd1, 5'h02, 8'h55, 4, 2'b00, 0, 0, 8'hFE, "fe-in-payload-R5");
    send_frame(3'd3, 5'h09, 8'h01, 1, 2'b00, 0, 0, 8'h80, "b2b-a-R7");
    send_frame(3'd2, 5'h0B, 8'h02, 6, 2'b01, 0, 0, 8'h40, "b2b-b-R7");
    t_overflow();
    send_frame(3'd1, 5'h16, 8'h9C, MAXP, 2'b00, 0, 0, 8'h05, "max-len-R8");
    send_frame(3'd2, 5'h03, 8'hE0, 1, 2'b10, 1, 1, 8'h99, "after-ovf");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule